// File: doc/BRIEF.md
# Encoder input conditioning filter

This block sits between the three raw pins of an incremental shaft encoder (phase A, phase B and the once-per-revolution index) and the decoder that counts them. Each pin is brought into the local clock domain through a short synchroniser chain. Each channel is then routed, optionally with A and B exchanged, polarity-corrected and gated by its own enable. Finally a digital glitch filter cleans the channel before it reaches the decoder.

The glitch filter samples its inputs on a tick from a prescaler. The tick rate comes from a 3-bit select with a non-uniform set of ratios: 1, 2, 4, 16, 32 and 64. A clean level is accepted only when the sample at a tick and the samples at the ticks just before it all agree. A bypass control skips the filter, so that the conditioned level is registered on every clock. For each channel the block presents a clean level and single-cycle rising and falling strobes, which is all a downstream quadrature decoder needs.

Top module: `qcond_input_filter`

## Requirements
- R1: With `filt_off`=1, a raw input change that is stable before rising edge k shows on `lvl` after edge k+2. That is the third rising edge, counting two synchroniser stages and the output register, and the matching strobe fires in that same cycle.
- R2: Bit 0 of `ch_en`, `ch_inv`, `lvl`, `rise` and `fall` belongs to channel A, bit 1 to channel B and bit 2 to the index channel.
- R3: A 1 in a `ch_inv` bit inverts that channel's polarity; a 0 passes it unchanged.
- R4: A 0 in a `ch_en` bit forces that channel's `lvl` to 0 from the next rising edge. It suppresses all of that channel's strobes, including the falling strobe when a high level is dropped.
- R5: With `swap_ab`=1, channel A is fed from `raw_b` and channel B from `raw_a`. The inversion and enable bits apply to the output channel. The index channel is unaffected.
- R6: With `filt_off`=0, a channel's level changes only at a sampling tick. It changes there only when the current sample and the previous FILT_LEN-1 tick samples (FILT_LEN=3 by default) all agree, so any shorter pulse is dropped.
- R7: `div_sel` codes 0,1,2,3,4,5 give a sampling tick every 1, 2, 4, 16, 32 and 64 clocks. The prescaler counts up from 0 after reset and ticks when it reaches ratio-1, then restarts from 0.
- R8: The reserved `div_sel` codes 6 and 7 tick on every clock, the same as code 0.
- R9: `rise` and `fall` last exactly one cycle and are never both high on one channel. They are high in the cycle that `lvl` becomes 1 or 0 respectively.
- R10: While `rst_n` is 0, `lvl`, `rise` and `fall` are 0. After release, the filter history reads as all zeros and the prescaler starts from 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_a | input | 1 | Raw encoder phase A pin |
| raw_b | input | 1 | Raw encoder phase B pin |
| raw_idx | input | 1 | Raw encoder index pin |
| div_sel | input | 3 | Sampling prescaler select |
| filt_off | input | 1 | 1 bypasses the glitch filter |
| ch_en | input | 3 | Per-channel enable (A, B, index) |
| ch_inv | input | 3 | Per-channel polarity inversion |
| swap_ab | input | 1 | Exchange phase A and phase B |
| lvl | output | 3 | Clean channel levels |
| rise | output | 3 | Rising-edge strobes |
| fall | output | 3 | Falling-edge strobes |

## Verification
The bench builds the block with its defaults: two synchroniser stages, a three-sample filter window and a 6-bit prescaler. With these values the slowest ratio of 64 needs about 200 clocks per accepted level, so every divider code, including the reserved ones, fits within one run. A three-deep window is short enough for deliberately short input bursts to fall just under or just over the acceptance threshold. Enables are toggled while levels are high, which shows whether a dropped channel leaks a falling strobe.

// File: rtl/qcond_pkg.sv
package qcond_pkg;

   localparam int NCH          = 3;
   localparam int CH_A         = 0;
   localparam int CH_B         = 1;
   localparam int CH_IDX       = 2;
   localparam int SEL_W        = 3;
   localparam int MAX_DIV_LOG2 = 6;

   // log2 of the sampling ratio for each select code; unused codes fall back to 1:1
   function automatic int unsigned div_log2(input logic [SEL_W-1:0] sel);
      case (sel)
         3'd0:    return 0;
         3'd1:    return 1;
         3'd2:    return 2;
         3'd3:    return 4;
         3'd4:    return 5;
         3'd5:    return 6;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/qcond_sync.sv
module qcond_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("qcond_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/qcond_tick.sv
module qcond_tick
   import qcond_pkg::*;
#(
   parameter int CW = MAX_DIV_LOG2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] div_sel,
   output logic             tick
);

   if (CW < MAX_DIV_LOG2) begin : g_bad_cw
      $error("qcond_tick: CW too narrow for the largest ratio");
   end

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   always_comb lim = CW'((1 << div_log2(div_sel)) - 1);

   // >= rather than == so that a switch to a smaller ratio never stalls
   assign tick = (cnt >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + CW'(1);
   end

endmodule

// File: rtl/qcond_glitch.sv
module qcond_glitch #(
   parameter int LEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic samp,
   input  logic en,
   input  logic bypass,
   output logic lvl,
   output logic rise,
   output logic fall
);

   if (LEN < 2) begin : g_bad_len
      $error("qcond_glitch: LEN must be at least 2");
   end

   logic [LEN-2:0] hist;
   logic [LEN-2:0] hist_nxt;
   logic [LEN-1:0] window;
   logic           agree;
   logic           nxt;

   if (LEN == 2) begin : g_hist1
      assign hist_nxt = samp;
   end else begin : g_histn
      assign hist_nxt = {hist[LEN-3:0], samp};
   end

   assign window = {hist, samp};
   assign agree  = (&window) | (~|window);

   always_comb begin
      if (!en)                nxt = 1'b0;
      else if (bypass)        nxt = samp;
      else if (tick && agree) nxt = samp;
      else                    nxt = lvl;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist <= '0;
         lvl  <= 1'b0;
         rise <= 1'b0;
         fall <= 1'b0;
      end else begin
         if (tick) hist <= hist_nxt;
         lvl  <= nxt;
         rise <= nxt & ~lvl;
         fall <= ~nxt & lvl & en;
      end
   end

endmodule

// File: rtl/qcond_input_filter.sv
module qcond_input_filter
   import qcond_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3,
   parameter int DIV_CW      = MAX_DIV_LOG2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             raw_a,
   input  logic             raw_b,
   input  logic             raw_idx,
   input  logic [SEL_W-1:0] div_sel,
   input  logic             filt_off,
   input  logic [NCH-1:0]   ch_en,
   input  logic [NCH-1:0]   ch_inv,
   input  logic             swap_ab,
   output logic [NCH-1:0]   lvl,
   output logic [NCH-1:0]   rise,
   output logic [NCH-1:0]   fall
);

   logic [NCH-1:0] raw_vec;
   logic [NCH-1:0] sync_vec;
   logic [NCH-1:0] routed;
   logic [NCH-1:0] cond;
   logic           tick;

   assign raw_vec = {raw_idx, raw_b, raw_a};

   qcond_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_vec),
      .q     (sync_vec)
   );

   always_comb begin
      routed = sync_vec;
      if (swap_ab) begin
         routed[CH_A] = sync_vec[CH_B];
         routed[CH_B] = sync_vec[CH_A];
      end
   end

   assign cond = (routed ^ ch_inv) & ch_en;

   qcond_tick #(.CW(DIV_CW)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .div_sel (div_sel),
      .tick    (tick)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      qcond_glitch #(.LEN(FILT_LEN)) u_flt (
         .clk    (clk),
         .rst_n  (rst_n),
         .tick   (tick),
         .samp   (cond[c]),
         .en     (ch_en[c]),
         .bypass (filt_off),
         .lvl    (lvl[c]),
         .rise   (rise[c]),
         .fall   (fall[c])
      );
   end

endmodule

// File: rtl/qcond_input_filter_chk.sv
module qcond_input_filter_chk
   import qcond_pkg::*;
(
   input logic           clk,
   input logic           rst_n,
   input logic [NCH-1:0] ch_en,
   input logic [NCH-1:0] lvl,
   input logic [NCH-1:0] rise,
   input logic [NCH-1:0] fall
);

   for (genvar c = 0; c < NCH; c++) begin : g_chk
      // R9
      edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(rise[c] && fall[c]));
      // R4
      off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !ch_en[c] |=> (!lvl[c] && !rise[c] && !fall[c]));
      // R9
      rise_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rise[c] |-> lvl[c]);
      // R9
      fall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
         fall[c] |-> !lvl[c]);
      // R9
      move_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(ch_en[c]) && !$stable(lvl[c])) |-> (rise[c] || fall[c]));
   end

endmodule

bind qcond_input_filter qcond_input_filter_chk u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .ch_en (ch_en),
   .lvl   (lvl),
   .rise  (rise),
   .fall  (fall)
);

// File: tb/sim_qcond_input_filter.sv
module sim_qcond_input_filter;

   localparam int FL = 3;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       raw_a, raw_b, raw_idx;
   logic [2:0] div_sel;
   logic       filt_off;
   logic [2:0] ch_en, ch_inv;
   logic       swap_ab;
   logic [2:0] lvl, rise, fall;

   always #5 clk = ~clk;

   qcond_input_filter u0 (
      .clk(clk), .rst_n(rst_n), .raw_a(raw_a), .raw_b(raw_b), .raw_idx(raw_idx),
      .div_sel(div_sel), .filt_off(filt_off), .ch_en(ch_en), .ch_inv(ch_inv),
      .swap_ab(swap_ab), .lvl(lvl), .rise(rise), .fall(fall)
   );

   int    vectors = 0;
   int    miscompares = 0;
   string tag = "R10 reset";
   bit    done = 1'b0;
   int    hold = 0;
   logic [15:0] lfsr = 16'hACE1;

   // behavioural reference
   logic [2:0] m_s1, m_s2, m_lvl, m_rise, m_fall;
   int         m_cnt;
   int         m_run [3];
   bit         m_last [3];

   function automatic int ratio_for(input logic [2:0] s);
      case (s)
         3'd1: return 2;
         3'd2: return 4;
         3'd3: return 16;
         3'd4: return 32;
         3'd5: return 64;
         default: return 1;
      endcase
   endfunction

   always @(posedge clk) begin
      logic [2:0] cond;
      bit         tk;
      bit         nxt;
      if (!rst_n) begin
         m_s1 = '0; m_s2 = '0; m_lvl = '0; m_rise = '0; m_fall = '0; m_cnt = 0;
         for (int c = 0; c < 3; c++) begin m_run[c] = FL - 1; m_last[c] = 1'b0; end
      end else begin
         cond[0] = swap_ab ? m_s2[1] : m_s2[0];
         cond[1] = swap_ab ? m_s2[0] : m_s2[1];
         cond[2] = m_s2[2];
         cond    = (cond ^ ch_inv) & ch_en;
         tk      = (m_cnt >= ratio_for(div_sel) - 1);
         m_cnt   = tk ? 0 : m_cnt + 1;
         for (int c = 0; c < 3; c++) begin
            if (tk) begin
               if (cond[c] == m_last[c]) m_run[c] = (m_run[c] < FL) ? m_run[c] + 1 : FL;
               else                      m_run[c] = 1;
               m_last[c] = cond[c];
            end
            if (!ch_en[c])                 nxt = 1'b0;
            else if (filt_off)             nxt = cond[c];
            else if (tk && m_run[c] >= FL) nxt = cond[c];
            else                           nxt = m_lvl[c];
            m_rise[c] = nxt & ~m_lvl[c];
            m_fall[c] = ~nxt & m_lvl[c] & ch_en[c];
            m_lvl[c]  = nxt;
         end
         m_s2 = m_s1;
         m_s1 = {raw_idx, raw_b, raw_a};
      end
   end

   // compare away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         vectors++;
         if (lvl !== m_lvl || rise !== m_rise || fall !== m_fall) begin
            miscompares++;
            $display("FAIL %s t=%0t lvl=%b exp %b rise=%b exp %b fall=%b exp %b",
                     tag, $time, lvl, m_lvl, rise, m_rise, fall, m_fall);
         end
      end
   end

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   task automatic check_zero(input string t);
      vectors++;
      if (lvl !== 3'b000 || rise !== 3'b000 || fall !== 3'b000) begin
         miscompares++;
         $display("FAIL %s lvl=%b rise=%b fall=%b exp 000 000 000", t, lvl, rise, fall);
      end
   endtask

   task automatic step_lfsr();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   endtask

   task automatic run_phase(input string t, input logic [2:0] ds, input bit fo,
                            input logic [2:0] en, input logic [2:0] inv, input bit sw,
                            input int n, input int hlo, input int hhi);
      tag = t; div_sel = ds; filt_off = fo; ch_en = en; ch_inv = inv; swap_ab = sw;
      for (int i = 0; i < n; i++) begin
         if (hold <= 0) begin
            step_lfsr(); step_lfsr();
            {raw_idx, raw_b, raw_a} = lfsr[2:0];
            hold = hlo + int'(lfsr[15:8]) % (hhi - hlo + 1);
         end
         hold--;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired in %s", tag);
         summary();
      end
   end

   initial begin
      rst_n = 1'b0; raw_a = 0; raw_b = 0; raw_idx = 0;
      div_sel = 3'd0; filt_off = 1'b1; ch_en = 3'b111; ch_inv = 3'b000; swap_ab = 1'b0;
      repeat (3) @(negedge clk);
      check_zero("R10 reset state");
      rst_n = 1'b1;
      @(negedge clk);

      // R1 / R2: bypass, straight routing, fast changes
      run_phase("R1 bypass latency", 3'd0, 1'b1, 3'b111, 3'b000, 1'b0, 300, 1, 4);
      run_phase("R2 channel order",  3'd0, 1'b1, 3'b111, 3'b000, 1'b0, 200, 2, 6);
      // R3 inversion
      run_phase("R3 inversion",      3'd0, 1'b1, 3'b111, 3'b101, 1'b0, 200, 1, 5);
      // R5 swap with inversion on the output channel
      run_phase("R5 swap",           3'd0, 1'b1, 3'b111, 3'b010, 1'b1, 200, 1, 5);
      run_phase("R5 swap filtered",  3'd0, 1'b0, 3'b011, 3'b001, 1'b1, 200, 2, 8);
      // R4 enables, including drop while high
      run_phase("R4 partial enable", 3'd0, 1'b1, 3'b101, 3'b000, 1'b0, 200, 1, 4);
      run_phase("R4 filtered enable",3'd0, 1'b0, 3'b010, 3'b000, 1'b0, 300, 2, 8);
      for (int k = 0; k < 8; k++) begin
         run_phase("R4 enable toggle", 3'd0, k[0], 3'(3'b111 ^ (3'(k) * 3'd3)), 3'b000,
                   1'b0, 40, 3, 8);
      end
      // R6 glitch rejection at the full rate
      run_phase("R6 glitch window",  3'd0, 1'b0, 3'b111, 3'b000, 1'b0, 600, 1, 6);
      // R7 each real divider code
      for (int d = 1; d <= 5; d++) begin
         run_phase("R7 divider", 3'(d), 1'b0, 3'b111, 3'b000, 1'b0,
                   ratio_for(3'(d)) * 70, ratio_for(3'(d)), ratio_for(3'(d)) * 5);
      end
      // R8 reserved codes
      run_phase("R8 reserved 6", 3'd6, 1'b0, 3'b111, 3'b000, 1'b0, 300, 1, 6);
      run_phase("R8 reserved 7", 3'd7, 1'b0, 3'b111, 3'b110, 1'b0, 300, 1, 6);
      // R9 strobes during slow filtered traffic
      run_phase("R9 strobes", 3'd2, 1'b0, 3'b111, 3'b000, 1'b0, 800, 4, 20);

      // R10 reset mid-run with levels high
      tag = "R10 mid reset";
      raw_a = 1; raw_b = 1; raw_idx = 1; filt_off = 1'b1; ch_inv = 3'b000;
      repeat (6) @(negedge clk);
      rst_n = 1'b0;
      #1;
      check_zero("R10 async clear");
      repeat (2) @(negedge clk);
      check_zero("R10 held in reset");
      raw_a = 0; raw_b = 0; raw_idx = 0; filt_off = 1'b0;
      rst_n = 1'b1;
      run_phase("R10 after release", 3'd1, 1'b0, 3'b111, 3'b000, 1'b0, 300, 2, 12);

      summary();
   end

endmodule